// File: doc/BRIEF.md
# Pin-Level Fault Injection Switch

This block sits in the path between a board's signals and the pins of a target device. Each point in the path is either a plain wire or, while an injection window is open, one of seven logical fault functions. The functions are forced constants, a released (high-impedance) pin, inversion, bridging with the adjacent point, and mixing with the pin's own last sampled value. Any number of the points, up to all of them, can be faulted in the same window.

Each point has its own mode field. A shared sequencer opens the window. Once armed, it waits for one of two events: a programmable delay counter reaching its terminal value, or a qualified bus cycle whose address equals a compare value. The window then stays open for a programmed number of cycles. It can reopen after a programmed gap, over and over, until the block is disarmed. Each point also keeps a sticky flag. The flag records whether the fault ever made the driven pin differ from its fault-free value, which tells the operator which faults actually took effect.

Top module: `pin_fault_switch`

## Requirements
- R1: When a point's mode is 0 (pass), or when no window is open, `pin_o` equals `pin_i` combinationally and `pin_oe_o` is 1. Point i's mode is at `mode_i[3i+2:3i]`.
- R2: During a window, mode 1 drives 0 and mode 2 drives 1, with `pin_oe_o` at 1.
- R3: During a window, mode 3 (open) drives `pin_oe_o` to 0 and `pin_o` to 0.
- R4: During a window, mode 4 drives the inverse of the point's input.
- R5: During a window, mode 5 drives `pin_i[i] & pin_i[(i+1) mod N]` and mode 6 drives `pin_i[i] | pin_i[(i+1) mod N]`. The last point's neighbour is point 0.
- R6: During a window, mode 7 drives `pin_i[i]` XOR the value of `pin_i[i]` sampled at the previous clock edge.
- R7: With `use_addr_i` at 0, `arm_i` sampled in idle at edge E0 opens the window after edge E(delay+1).
- R8: With `use_addr_i` at 1, the window opens after the first edge at which `bus_valid_i` is 1 and `bus_addr_i` equals `match_addr_i`. The delay counter has no effect in this case.
- R9: A window lasts `dur_i` cycles, or 1 cycle if `dur_i` is 0. If `gap_i` is nonzero, the next window opens after `gap_i` closed cycles. If `gap_i` is 0, the block returns to idle after one window.
- R10: `disarm_i` returns the block to idle at the next edge from any state, with priority over every other input.
- R11: `act_o[i]` is set at the edge after a cycle in which the window was open and point i's output differed from `pin_i[i]` or was released. Nothing sets it while no window is open.
- R12: A 1 on `act_clr_i[i]` clears `act_o[i]` at the next edge, but a set in the same cycle wins.
- R13: After reset the window is closed and all `act_o` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_PINS | Fault-free board signals |
| pin_o | output | N_PINS | Values driven to the target pins |
| pin_oe_o | output | N_PINS | Drive enable per pin, 0 means released |
| mode_i | input | 3*N_PINS | Fault mode per point |
| arm_i | input | 1 | Start waiting for a trigger (idle only) |
| disarm_i | input | 1 | Return to idle |
| use_addr_i | input | 1 | 1 selects address trigger, 0 selects delay counter |
| delay_i | input | CNT_W | Trigger delay in cycles |
| dur_i | input | CNT_W | Window length in cycles |
| gap_i | input | CNT_W | Closed cycles between windows, 0 for single shot |
| bus_addr_i | input | ADDR_W | Observed bus address |
| bus_valid_i | input | 1 | Observed bus address is valid |
| match_addr_i | input | ADDR_W | Address compare value |
| act_clr_i | input | N_PINS | Write-one-to-clear for activation flags |
| act_o | output | N_PINS | Sticky activation flags |
| inj_active_o | output | 1 | Injection window open |

## Verification
The pin outputs are combinational from `pin_i`, the mode and the window state, so the bench checks them in the same low clock phase in which it applies a pattern. The history mode uses the pattern applied one cycle earlier. The window state is one register after the sampling edge. The bench counts edges from the arm or match edge and compares `inj_active_o` at every falling edge with a window start computed arithmetically as delay+1 plus multiples of dur+gap. Activation flags lag the faulted cycle by one edge, so the bench reads them one cycle after the cause and again after the window closes.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    FM_PASS = 3'd0,
    FM_SA0  = 3'd1,
    FM_SA1  = 3'd2,
    FM_OPEN = 3'd3,
    FM_INV  = 3'd4,
    FM_AND  = 3'd5,
    FM_OR   = 3'd6,
    FM_HIST = 3'd7
  } fmode_e;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_WAIT,
    TS_ON,
    TS_OFF
  } tstate_e;
endpackage

// File: rtl/pfi_trigger.sv
module pfi_trigger
  import pfi_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              use_addr_i,
  input  logic [CNT_W-1:0]  delay_i,
  input  logic [CNT_W-1:0]  dur_i,
  input  logic [CNT_W-1:0]  gap_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] match_addr_i,
  output logic              active_o
);
  tstate_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             addr_hit, fire;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign addr_hit = bus_valid_i && (bus_addr_i == match_addr_i);
  assign fire     = use_addr_i ? addr_hit : (cnt_q == delay_i);
  assign active_o = (state_q == TS_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      cnt_q   <= '0;
    end else if (disarm_i) begin
      state_q <= TS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        TS_IDLE: if (arm_i) begin
          state_q <= TS_WAIT;
          cnt_q   <= '0;
        end
        TS_WAIT: begin
          if (fire) begin
            state_q <= TS_ON;
            cnt_q   <= '0;
          end else if (!use_addr_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TS_ON: begin
          if (cnt_inc >= {1'b0, dur_i}) begin
            cnt_q   <= '0;
            state_q <= (gap_i == '0) ? TS_IDLE : TS_OFF;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TS_OFF: begin
          if (cnt_inc >= {1'b0, gap_i}) begin
            cnt_q   <= '0;
            state_q <= TS_ON;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end

  // R10
  disarm_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> !active_o);

  // R7
  idle_stays_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_IDLE && !arm_i) |=> !active_o);

  // R8
  addr_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_WAIT && use_addr_i && !addr_hit && !disarm_i) |=> (state_q == TS_WAIT));

  // R9
  window_from_wait_or_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(state_q) == TS_WAIT || $past(state_q) == TS_OFF));
endmodule

// File: rtl/pfi_point.sv
module pfi_point
  import pfi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              nbr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              active_i,
  input  logic              clr_i,
  output logic              pin_o,
  output logic              oe_o,
  output logic              act_o
);
  logic prev_q, act_q, differ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  always_comb begin
    pin_o = pin_i;
    oe_o  = 1'b1;
    if (active_i) begin
      case (fmode_e'(mode_i))
        FM_SA0:  pin_o = 1'b0;
        FM_SA1:  pin_o = 1'b1;
        FM_OPEN: begin
          pin_o = 1'b0;
          oe_o  = 1'b0;
        end
        FM_INV:  pin_o = ~pin_i;
        FM_AND:  pin_o = pin_i & nbr_i;
        FM_OR:   pin_o = pin_i | nbr_i;
        FM_HIST: pin_o = pin_i ^ prev_q;
        default: pin_o = pin_i;
      endcase
    end
  end

  assign differ = !oe_o || (pin_o != pin_i);

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= (act_q & ~clr_i) | (active_i & differ);
  end

  assign act_o = act_q;

  // R1
  closed_is_wire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (pin_o == pin_i && oe_o));

  // R11
  act_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(active_i));

  // R12
  act_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !clr_i) |=> act_q);
endmodule

// File: rtl/pin_fault_switch.sv
module pin_fault_switch
  import pfi_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PINS-1:0]        pin_i,
  output logic [N_PINS-1:0]        pin_o,
  output logic [N_PINS-1:0]        pin_oe_o,
  input  logic [MODE_W*N_PINS-1:0] mode_i,
  input  logic                     arm_i,
  input  logic                     disarm_i,
  input  logic                     use_addr_i,
  input  logic [CNT_W-1:0]         delay_i,
  input  logic [CNT_W-1:0]         dur_i,
  input  logic [CNT_W-1:0]         gap_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic                     bus_valid_i,
  input  logic [ADDR_W-1:0]        match_addr_i,
  input  logic [N_PINS-1:0]        act_clr_i,
  output logic [N_PINS-1:0]        act_o,
  output logic                     inj_active_o
);
  logic active;

  pfi_trigger #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .disarm_i     (disarm_i),
    .use_addr_i   (use_addr_i),
    .delay_i      (delay_i),
    .dur_i        (dur_i),
    .gap_i        (gap_i),
    .bus_addr_i   (bus_addr_i),
    .bus_valid_i  (bus_valid_i),
    .match_addr_i (match_addr_i),
    .active_o     (active)
  );

  assign inj_active_o = active;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pt
    localparam int NBR = (i + 1) % N_PINS;  // wraps to point 0
    pfi_point u_pt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[i]),
      .nbr_i    (pin_i[NBR]),
      .mode_i   (mode_i[MODE_W*i +: MODE_W]),
      .active_i (active),
      .clr_i    (act_clr_i[i]),
      .pin_o    (pin_o[i]),
      .oe_o     (pin_oe_o[i]),
      .act_o    (act_o[i])
    );
  end

  // R13
  reset_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!inj_active_o && act_o == '0));
endmodule

// File: tb/sim_pin_fault_switch.sv
module sim_pin_fault_switch;
  localparam int N = 4;
  localparam int CW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_i = '0;
  logic [N-1:0]  pin_o, oe, act;
  logic [3*N-1:0] mode = '0;
  logic          arm = 0, disarm = 0, use_addr = 0, bus_valid = 0, active;
  logic [CW-1:0] delay = '0, dur = '0, gap = '0;
  logic [AW-1:0] bus_addr = '0, match = 8'hA5;
  logic [N-1:0]  clr = '0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_fault_switch #(.N_PINS(N), .CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(oe),
    .mode_i(mode), .arm_i(arm), .disarm_i(disarm), .use_addr_i(use_addr),
    .delay_i(delay), .dur_i(dur), .gap_i(gap), .bus_addr_i(bus_addr),
    .bus_valid_i(bus_valid), .match_addr_i(match), .act_clr_i(clr),
    .act_o(act), .inj_active_o(active)
  );

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1 pass";
      1, 2: return "R2 stuck";
      3: return "R3 open";
      4: return "R4 invert";
      5, 6: return "R5 bridge";
      default: return "R6 history";
    endcase
  endfunction

  task automatic arm_pulse();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic disarm_pulse();
    @(negedge clk); disarm = 1;
    @(negedge clk); disarm = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] lastp;
    pin_i = 4'b1001;
    #35 rst_n = 1;
    @(negedge clk);
    // R13
    chk("R13 active", {31'd0, active}, 0);
    chk("R13 act", {28'd0, act}, 0);
    chk("R1 reset pass", {24'd0, oe, pin_o}, {24'd0, 4'hF, 4'b1001});

    // mode sweep in one long window (R1..R6, R7 delay 0)
    dur = 8'd250; gap = 0; delay = 0; use_addr = 0;
    arm_pulse();
    @(negedge clk);
    chk("R7 delay0 open", {31'd0, active}, 1);
    lastp = pin_i;
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        for (int i = 0; i < N; i++) mode[3*i +: 3] = 3'((m + i) % 8);
        pin_i = 4'(p);
        #5;
        for (int i = 0; i < N; i++) begin
          int md;
          logic ei, eo, nb;
          md = (m + i) % 8;
          nb = pin_i[(i + 1) % N];
          eo = 1'b1;
          case (md)
            0: ei = pin_i[i];
            1: ei = 1'b0;
            2: ei = 1'b1;
            3: begin ei = 1'b0; eo = 1'b0; end
            4: ei = ~pin_i[i];
            5: ei = pin_i[i] & nb;
            6: ei = pin_i[i] | nb;
            default: ei = pin_i[i] ^ lastp[i];
          endcase
          chk(tag_of(md), {30'd0, oe[i], pin_o[i]}, {30'd0, eo, ei});
        end
        lastp = pin_i;
      end
    end
    disarm_pulse();
    // R10 closed after disarm; R1 modes ignored while closed
    chk("R10 closed", {31'd0, active}, 0);
    mode = {4{3'd2}};
    pin_i = 4'b0101;
    #5;
    chk("R1 closed wire", {24'd0, oe, pin_o}, {24'd0, 4'hF, 4'b0101});

    // repeating timer windows (R7, R9), then disarm mid-window (R10)
    mode = '0;
    delay = 8'd3; dur = 8'd4; gap = 8'd2;
    arm_pulse();
    for (int j = 1; j <= 40; j++) begin
      int e;
      @(negedge clk);
      e = (j >= 4 && ((j - 4) % 6) < 4) ? 1 : 0;
      chk("R7/R9 timer window", {31'd0, active}, 32'(e));
    end
    disarm = 1;
    @(negedge clk); disarm = 0;
    chk("R10 disarm in window", {31'd0, active}, 0);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R10 stays idle", {31'd0, active}, 0);
    end

    // single shot
    delay = 0; dur = 8'd3; gap = 0;
    arm_pulse();
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      chk("R9 single shot", {31'd0, active}, (j <= 3) ? 1 : 0);
    end

    // address trigger (R8): delay 0 would fire at once in timer mode
    use_addr = 1; bus_valid = 1; bus_addr = 8'h11;
    arm_pulse();
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (j == 2) begin bus_addr = 8'hA5; bus_valid = 0; end
      else if (j == 3) bus_addr = 8'h11;
      chk("R8 no match", {31'd0, active}, 0);
    end
    @(negedge clk); bus_addr = 8'hA5; bus_valid = 1;
    @(negedge clk); bus_valid = 0; bus_addr = 8'h00;
    for (int j = 1; j <= 5; j++) begin
      chk("R8 match window", {31'd0, active}, (j <= 3) ? 1 : 0);
      @(negedge clk);
    end
    use_addr = 0;

    // activation flags (R11, R12)
    clr = 4'hF;
    @(negedge clk); clr = 0;
    mode = {3'd4, 3'd0, 3'd1, 3'd2};
    pin_i = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R11 idle no set", {28'd0, act}, 0);
    delay = 0; dur = 8'd5; gap = 0;
    arm_pulse();
    @(negedge clk);  // j=1, open
    @(negedge clk);  // j=2
    chk("R11 set one edge later", {28'd0, act}, {28'd0, 4'b1010});
    clr = 4'b0010;
    @(negedge clk); clr = 0;
    chk("R12 set wins", {28'd0, act}, {28'd0, 4'b1010});
    repeat (4) @(negedge clk);
    chk("R11 window over", {31'd0, active}, 0);
    chk("R11 sticky", {28'd0, act}, {28'd0, 4'b1010});
    clr = 4'b0010;
    @(negedge clk); clr = 0;
    chk("R12 clear", {28'd0, act}, {28'd0, 4'b1000});

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule